// File: doc/BRIEF.md
# PHY Discovery and Status Sequencer

This block brings up an Ethernet PHY by driving a management-bus master through a simple request/done handshake. After a start pulse it reads the two identifier registers of the PHY at address 0, builds a 32-bit identifier and decides whether the device is a recognised model. It then reads the basic status register and turns four of its bits into fault and state flags.

When the device is recognised, the sequencer also reads a vendor status register to learn link validity, speed and duplex. It then writes a fixed LED configuration word. For an unrecognised device those two accesses are skipped and the speed, duplex and link-valid outputs stay low. A one-cycle done pulse marks the end. All results are registered and hold until the next start. The serial wire protocol lives in the master below this block.

Top module: `phy_probe_seq`

## Requirements
- R1: After reset, req_valid, seq_done and every result output are 0.
- R2: A start pulse while idle clears the results and launches the sequence. The first two accesses are reads of register 2 and then register 3. phy_id = {register 2 data, register 3 data}. Every access uses PHY address 0.
- R3: Only one request is outstanding. req_valid, req_reg, req_write and req_wdata hold until the cycle where rsp_done is high, req_valid then drops for at least one cycle, and rsp_done while req_valid is low is ignored.
- R4: dev_known is 1 exactly when (phy_id & 0xFFFFFC00) == 0x00137800 and (phy_id & 0x000003F0) == 0x000000E0. dev_rev always shows phy_id[3:0].
- R5: The third access reads register 1. The flags are taken from its data: link_down = !bit2, aneg_incomplete = !bit5, jabber = bit1, remote_fault = bit4.
- R6: For a known device the fourth access reads register 17. link_valid = bit10, speed_100 = bit14 and full_duplex = bit9.
- R7: For a known device the final access is a write (req_write = 1) of 0x0452 to register 20.
- R8: For an unknown device, registers 17 and 20 are never accessed, and speed_100, full_duplex and link_valid stay 0.
- R9: seq_done pulses for exactly one cycle after the last access completes. The results hold their values until the next accepted start.
- R10: A start pulse that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse |
| req_valid | output | 1 | Access request to the management master |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | 5 | PHY address of the request |
| req_reg | output | 5 | Register number of the request |
| req_wdata | output | 16 | Write data |
| rsp_done | input | 1 | Access complete (one-cycle pulse) |
| rsp_rdata | input | 16 | Read data, valid with rsp_done |
| phy_id | output | 32 | Identifier {reg2, reg3} |
| dev_known | output | 1 | Recognised device |
| dev_rev | output | 4 | Revision field of the identifier |
| link_down | output | 1 | Link down flag |
| aneg_incomplete | output | 1 | Autonegotiation not complete |
| jabber | output | 1 | Jabber detected |
| remote_fault | output | 1 | Remote fault detected |
| speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | output | 1 | 1 = full duplex |
| link_valid | output | 1 | Vendor register reports a valid link |
| seq_done | output | 1 | End-of-sequence pulse |

## Verification
The assertions assume that the master raises rsp_done only while a request is pending and for a single cycle. The bench's responder model keeps to this: it answers each request once, after a latency that varies from case to case. A separate stray-done test pulses rsp_done while no request is pending, which the design must ignore. A scoreboard compares the order, direction, register and data of every request with the expected list for each identifier pattern, including the case where a second start arrives in the middle of a run.

// File: rtl/phy_probe_pkg.sv
package phy_probe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ID_HI, ST_ID_LO, ST_STAT, ST_VEND, ST_LED, ST_FIN
  } step_t;
endpackage

// File: rtl/phy_probe_ctrl.sv
module phy_probe_ctrl
  import phy_probe_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int PHY_W      = 5,
  parameter int DATA_W     = 16,
  parameter int PHY_ADDR   = 0,
  parameter int REG_ID_HI  = 2,
  parameter int REG_ID_LO  = 3,
  parameter int REG_STAT   = 1,
  parameter int REG_VEND   = 17,
  parameter int REG_LED    = 20,
  parameter int LED_CFG    = 16'h0452
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dev_known,
  input  logic              rsp_done,
  output logic              req_valid,
  output logic              req_write,
  output logic [PHY_W-1:0]  req_phy,
  output logic [REG_W-1:0]  req_reg,
  output logic [DATA_W-1:0] req_wdata,
  output step_t             step,
  output logic              launch,
  output logic              accept,
  output logic              seq_done
);
  step_t            nxt_step;
  logic [REG_W-1:0] step_reg;

  assign launch  = (step == ST_IDLE) && start;
  assign accept  = req_valid && rsp_done;
  assign req_phy = PHY_W'(PHY_ADDR);

  always_comb begin
    case (step)
      ST_ID_HI: begin nxt_step = ST_ID_LO; step_reg = REG_W'(REG_ID_HI); end
      ST_ID_LO: begin nxt_step = ST_STAT;  step_reg = REG_W'(REG_ID_LO); end
      ST_STAT:  begin nxt_step = dev_known ? ST_VEND : ST_FIN; step_reg = REG_W'(REG_STAT); end
      ST_VEND:  begin nxt_step = ST_LED;   step_reg = REG_W'(REG_VEND); end
      ST_LED:   begin nxt_step = ST_FIN;   step_reg = REG_W'(REG_LED); end
      default:  begin nxt_step = ST_IDLE;  step_reg = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step      <= ST_IDLE;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_reg   <= '0;
      req_wdata <= '0;
      seq_done  <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      case (step)
        ST_IDLE: if (start) step <= ST_ID_HI;
        ST_FIN: begin
          seq_done <= 1'b1;
          step     <= ST_IDLE;
        end
        default: begin
          if (!req_valid) begin
            req_valid <= 1'b1;
            req_reg   <= step_reg;
            req_write <= (step == ST_LED);
            req_wdata <= (step == ST_LED) ? DATA_W'(LED_CFG) : '0;
          end else if (rsp_done) begin
            req_valid <= 1'b0;
            step      <= nxt_step;
          end
        end
      endcase
    end
  end

  // R3: a pending request holds all of its fields until it is answered
  a_r3_hold_req: assert property (@(posedge clk) disable iff (rst)
    req_valid && !rsp_done |=> req_valid && $stable(req_reg) && $stable(req_write) && $stable(req_wdata));
  // R3: an answered request leaves a gap before the next one
  a_r3_gap: assert property (@(posedge clk) disable iff (rst)
    req_valid && rsp_done |=> !req_valid);
  // R8: an unrecognised device never sees the vendor or LED registers
  a_r8_skip_vendor: assert property (@(posedge clk) disable iff (rst)
    req_valid && !dev_known |-> (req_reg != REG_W'(REG_VEND)) && (req_reg != REG_W'(REG_LED)));
  // R9: the done pulse lasts one cycle and no request is pending with it
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> !req_valid);
endmodule

// File: rtl/phy_probe_decode.sv
module phy_probe_decode
  import phy_probe_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter logic [31:0] VEND_MASK = 32'hFFFF_FC00,
  parameter logic [31:0] VEND_VAL  = 32'h0013_7800,
  parameter logic [31:0] MODEL_MASK = 32'h0000_03F0,
  parameter logic [31:0] MODEL_VAL  = 32'h0000_00E0,
  parameter int          REV_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              accept,
  input  step_t             step,
  input  logic [DATA_W-1:0] rdata,
  output logic [2*DATA_W-1:0] phy_id,
  output logic              dev_known,
  output logic [REV_W-1:0]  dev_rev,
  output logic              link_down,
  output logic              aneg_incomplete,
  output logic              jabber,
  output logic              remote_fault,
  output logic              speed_100,
  output logic              full_duplex,
  output logic              link_valid
);
  localparam int ID_W      = 2 * DATA_W;
  localparam int B_JABBER  = 1;
  localparam int B_LINK    = 2;
  localparam int B_RFAULT  = 4;
  localparam int B_ANEG    = 5;
  localparam int B_DUPLEX  = 9;
  localparam int B_LVALID  = 10;
  localparam int B_SPEED   = 14;

  logic [ID_W-1:0] full_id;
  logic            id_match;

  assign full_id  = {phy_id[ID_W-1:DATA_W], rdata};
  assign id_match = ((full_id & VEND_MASK) == VEND_VAL) && ((full_id & MODEL_MASK) == MODEL_VAL);

  always_ff @(posedge clk) begin
    if (rst || launch) begin
      phy_id          <= '0;
      dev_known       <= 1'b0;
      dev_rev         <= '0;
      link_down       <= 1'b0;
      aneg_incomplete <= 1'b0;
      jabber          <= 1'b0;
      remote_fault    <= 1'b0;
      speed_100       <= 1'b0;
      full_duplex     <= 1'b0;
      link_valid      <= 1'b0;
    end else if (accept) begin
      case (step)
        ST_ID_HI: phy_id[ID_W-1:DATA_W] <= rdata;
        ST_ID_LO: begin
          phy_id[DATA_W-1:0] <= rdata;
          dev_known          <= id_match;
          dev_rev            <= rdata[REV_W-1:0];
        end
        ST_STAT: begin
          link_down       <= !rdata[B_LINK];
          aneg_incomplete <= !rdata[B_ANEG];
          jabber          <= rdata[B_JABBER];
          remote_fault    <= rdata[B_RFAULT];
        end
        ST_VEND: begin
          link_valid  <= rdata[B_LVALID];
          speed_100   <= rdata[B_SPEED];
          full_duplex <= rdata[B_DUPLEX];
        end
        default: ;
      endcase
    end
  end

  // R4: a recognised device always carries the vendor identifier
  a_r4_known_match: assert property (@(posedge clk) disable iff (rst)
    dev_known |-> ((phy_id & VEND_MASK) == VEND_VAL) && ((phy_id & MODEL_MASK) == MODEL_VAL));
  // R8: link details stay low for an unrecognised device
  a_r8_zero_link: assert property (@(posedge clk) disable iff (rst)
    !dev_known |-> !speed_100 && !full_duplex && !link_valid);
endmodule

// File: rtl/phy_probe_seq.sv
module phy_probe_seq
  import phy_probe_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int PHY_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic                req_valid,
  output logic                req_write,
  output logic [PHY_W-1:0]    req_phy,
  output logic [REG_W-1:0]    req_reg,
  output logic [DATA_W-1:0]   req_wdata,
  input  logic                rsp_done,
  input  logic [DATA_W-1:0]   rsp_rdata,
  output logic [2*DATA_W-1:0] phy_id,
  output logic                dev_known,
  output logic [3:0]          dev_rev,
  output logic                link_down,
  output logic                aneg_incomplete,
  output logic                jabber,
  output logic                remote_fault,
  output logic                speed_100,
  output logic                full_duplex,
  output logic                link_valid,
  output logic                seq_done
);
  step_t step;
  logic  launch;
  logic  accept;

  phy_probe_ctrl #(.REG_W(REG_W), .PHY_W(PHY_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .dev_known(dev_known), .rsp_done(rsp_done),
    .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .step(step), .launch(launch), .accept(accept), .seq_done(seq_done)
  );

  phy_probe_decode #(.DATA_W(DATA_W), .REV_W(4)) u_decode (
    .clk(clk), .rst(rst), .launch(launch), .accept(accept), .step(step), .rdata(rsp_rdata),
    .phy_id(phy_id), .dev_known(dev_known), .dev_rev(dev_rev), .link_down(link_down),
    .aneg_incomplete(aneg_incomplete), .jabber(jabber), .remote_fault(remote_fault),
    .speed_100(speed_100), .full_duplex(full_duplex), .link_valid(link_valid)
  );
endmodule

// File: tb/tb_phy_probe_seq.sv
module tb_phy_probe_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic req_valid, req_write, dev_known, link_down, aneg_incomplete, jabber;
  logic remote_fault, speed_100, full_duplex, link_valid, seq_done;
  logic [4:0] req_phy, req_reg;
  logic [15:0] req_wdata;
  logic rsp_done = 1'b0;
  logic [15:0] rsp_rdata = '0;
  logic [31:0] phy_id;
  logic [3:0] dev_rev;

  always #10 clk = ~clk;

  phy_probe_seq dut (
    .clk(clk), .rst(rst), .start(start), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .phy_id(phy_id), .dev_known(dev_known), .dev_rev(dev_rev),
    .link_down(link_down), .aneg_incomplete(aneg_incomplete), .jabber(jabber),
    .remote_fault(remote_fault), .speed_100(speed_100), .full_duplex(full_duplex),
    .link_valid(link_valid), .seq_done(seq_done)
  );

  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  int cycles = 0;
  int lat = 0;
  int wait_cnt = 0;
  logic stray = 1'b0;
  logic prev_v = 1'b0;
  logic [15:0] phy_regs [32];
  logic [21:0] exp_q [$];   // {write, reg[4:0], data[15:0]}

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Responder and scoreboard monitor, both at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (rsp_done) rsp_done <= 1'b0;
    else if (stray) begin
      rsp_done  <= 1'b1;
      rsp_rdata <= 16'hDEAD;
      stray     <= 1'b0;
    end else if (req_valid) begin
      if (wait_cnt >= lat) begin
        rsp_done  <= 1'b1;
        rsp_rdata <= phy_regs[req_reg];
        wait_cnt  <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
    if (seq_done) done_cnt++;
    if (req_valid && !prev_v) begin
      if (exp_q.size() == 0) chk("R8 unexpected request", {req_write, req_reg}, 32'hFFFF);
      else begin
        logic [21:0] e;
        e = exp_q.pop_front();
        chk("R2 request phy address", req_phy, 0);
        chk("R2/R5/R6/R7 request kind/reg", {req_write, req_reg}, {e[21], e[20:16]});
        if (e[21]) chk("R7 write data", req_wdata, e[15:0]);
      end
    end
    prev_v <= req_valid;
  end

  initial begin
    while (cycles < 100000) @(negedge clk);
    chk("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_case(input logic [31:0] id, input logic [15:0] stat,
                          input logic [15:0] vend, input int l, input bit mid_start);
    bit known;
    int d0;
    known = ((id & 32'hFFFF_FC00) == 32'h0013_7800) && ((id & 32'h3F0) == 32'hE0);
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'hFFFF;
    phy_regs[2] = id[31:16]; phy_regs[3] = id[15:0];
    phy_regs[1] = stat; phy_regs[17] = vend;
    lat = l;
    exp_q.push_back({1'b0, 5'd2, 16'h0});
    exp_q.push_back({1'b0, 5'd3, 16'h0});
    exp_q.push_back({1'b0, 5'd1, 16'h0});
    if (known) begin
      exp_q.push_back({1'b0, 5'd17, 16'h0});
      exp_q.push_back({1'b1, 5'd20, 16'h0452});
    end
    d0 = done_cnt;
    pulse_start();
    if (mid_start) begin
      repeat (5) @(negedge clk);
      pulse_start();   // R10: must be ignored
    end
    for (int i = 0; i < 2000 && done_cnt == d0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R9/R10 single done pulse", done_cnt - d0, 1);
    chk("R3/R10 all requests seen", exp_q.size(), 0);
    exp_q.delete();
    chk("R2 phy_id", phy_id, id);
    chk("R4 dev_known", dev_known, known);
    chk("R4 dev_rev", dev_rev, id[3:0]);
    chk("R5 link_down", link_down, !stat[2]);
    chk("R5 aneg_incomplete", aneg_incomplete, !stat[5]);
    chk("R5 jabber", jabber, stat[1]);
    chk("R5 remote_fault", remote_fault, stat[4]);
    chk("R6/R8 link_valid", link_valid, known ? vend[10] : 1'b0);
    chk("R6/R8 speed_100", speed_100, known ? vend[14] : 1'b0);
    chk("R6/R8 full_duplex", full_duplex, known ? vend[9] : 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 req_valid", req_valid, 0);
    chk("R1 seq_done", seq_done, 0);
    chk("R1 results", {phy_id, dev_known, dev_rev, link_down, aneg_incomplete, jabber,
        remote_fault, speed_100, full_duplex, link_valid}, 0);
    run_case(32'h0013_78E5, 16'h0024, 16'h4600, 0, 0);
    run_case(32'h0013_78EA, 16'h0012, 16'h0200, 3, 0);
    run_case(32'h0013_7BF2, 16'h0036, 16'hFFFF, 1, 0);
    run_case(32'h0022_1555, 16'h0004, 16'hFFFF, 2, 1);
    run_case(32'h0013_78E0, 16'h0020, 16'h4400, 2, 1);
    // R3/R9: stray done while idle leaves results untouched and issues nothing
    stray = 1'b1;
    repeat (5) @(negedge clk);
    chk("R3 stray done ignored id", phy_id, 32'h0013_78E0);
    chk("R9 results held", {speed_100, link_valid, full_duplex}, 3'b110);
    chk("R3 no request after stray", req_valid, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule